// File: doc/BRIEF.md
# Dual-Issue Pairing Cycle Counter

This block estimates how many cycles a simple two-wide, in-order machine would need for a stream of already retired instructions. Each instruction arrives on a valid strobe with a 4-bit functional-unit class code and a hazard flag. The hazard flag comes from an external dependency checker. The block keeps an issue quota for every class and a slot budget for the current cycle. For each instruction it decides whether the instruction joins the open issue group or starts a new one.

Two counters come out of the block. One counts issue groups, which stand for estimated cycles. The other counts group breaks caused by a dependency hazard. Compare, branch and jump instructions may appear at most once per group. Every other class may appear twice, within the overall budget of two slots. The block is placed beside a retirement stream purely as a performance-estimation probe. It handles at most one instruction per clock.

Top module: `issue_pair_counter`

## Requirements
- R1: While reset is asserted, both counters read 0. Reset also empties the quotas and the slot budget, so the first valid instruction after reset always opens a new group.
- R2: When an instruction opens a new group, the group counter rises by one on the clock edge that accepts the instruction.
- R3: Every group has two slots. A third instruction in a row without a hazard opens a new group, even when its class quota is not used up.
- R4: Class codes 2 (compare), 3 (branch) and 4 (jump) have a quota of one per group. A second instruction of the same one of these classes opens a new group.
- R5: All other classes have a quota of two per group: 0 unknown, 1 shift, 5 extend, 6 nop, 7 move, 8 move-immediate, 9 arith, 10 store and 11 load. Codes 12 to 15 are counted as class 0. Two such instructions share one group.
- R6: An instruction with the hazard flag set always opens a new group. It raises the hazard counter by one on the same edge as the group counter.
- R7: While in_valid is low, the class and hazard inputs have no effect on the counters or on the quota and slot state.
- R8: Both counters saturate at their all-ones value instead of wrapping.
- R9: Quotas are kept separately for each class. A compare, a branch and a jump are separate classes, so a compare followed by a branch shares one group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A retired instruction is presented this cycle |
| in_class | input | 4 | Functional-unit class code |
| in_hazard | input | 1 | Dependency hazard on the previous instruction |
| group_count | output | CNT_W | Number of issue groups opened |
| hazard_count | output | CNT_W | Number of group breaks caused by a hazard |

## Verification
A quota or slot budget that holds a wrong value shows up at the next instruction of the affected class: the group counter moves one edge too early, or fails to move when it should. Each scenario therefore follows a short instruction train with a check after every accepted instruction, so a break at the wrong position is seen at once. Idle cycles that carry hazard and class values are followed by an instruction whose grouping depends on the untouched state. Saturation is observed on a narrow second instance that shares the same inputs.

// File: rtl/issue_pair_counter.sv
module issue_pair_counter #(
  parameter int CNT_W     = 32,
  parameter int CLASS_W   = 4,
  parameter int SLOTS     = 2,
  parameter int QUOTA_ONE = 1,
  parameter int QUOTA_TWO = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [CLASS_W-1:0] in_class,
  input  logic               in_hazard,
  output logic [CNT_W-1:0]   group_count,
  output logic [CNT_W-1:0]   hazard_count
);

  localparam int NCLS = 12;
  localparam int IW   = $clog2(NCLS);
  localparam int QW   = $clog2(QUOTA_TWO + 1);
  localparam int SW   = $clog2(SLOTS + 1);
  localparam int CLS_CMP = 2;
  localparam int CLS_BR  = 3;
  localparam int CLS_JMP = 4;

  logic [QW-1:0]    quota_q [NCLS];
  logic [SW-1:0]    slots_q;
  logic [CNT_W-1:0] grp_q, haz_q;
  logic [IW-1:0]    idx;
  logic             open_grp;

  function automatic logic [QW-1:0] reload_of(input int i);
    if (i == CLS_CMP || i == CLS_BR || i == CLS_JMP) return QW'(QUOTA_ONE);
    return QW'(QUOTA_TWO);
  endfunction

  assign idx      = (int'(in_class) < NCLS) ? IW'(in_class) : '0;
  assign open_grp = (quota_q[idx] == '0) || in_hazard || (slots_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCLS; i++) quota_q[i] <= '0;
      slots_q <= '0;
      grp_q   <= '0;
      haz_q   <= '0;
    end else if (in_valid) begin
      for (int i = 0; i < NCLS; i++) begin
        if (open_grp)
          quota_q[i] <= (i == int'(idx)) ? reload_of(i) - QW'(1) : reload_of(i);
        else if (i == int'(idx))
          quota_q[i] <= quota_q[i] - QW'(1);
      end
      slots_q <= open_grp ? SW'(SLOTS - 1) : slots_q - SW'(1);
      if (open_grp && grp_q != '1) grp_q <= grp_q + CNT_W'(1);
      if (open_grp && in_hazard && haz_q != '1) haz_q <= haz_q + CNT_W'(1);
    end
  end

  assign group_count  = grp_q;
  assign hazard_count = haz_q;

endmodule

// File: rtl/issue_pair_counter_chk.sv
module issue_pair_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_hazard,
  input logic [CNT_W-1:0] group_count,
  input logic [CNT_W-1:0] hazard_count
);

  assert_hazard_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_hazard) |=>
      (group_count == $past(group_count) + CNT_W'(1)) || (&$past(group_count)));

  assert_hazard_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_hazard) |=>
      (hazard_count == $past(hazard_count) + CNT_W'(1)) || (&$past(hazard_count)));

  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(group_count) && $stable(hazard_count));

  assert_no_hazard_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_hazard) |=> $stable(hazard_count));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (group_count - $past(group_count)) <= CNT_W'(1));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> group_count >= $past(group_count) && hazard_count >= $past(hazard_count));

  assert_hazard_le_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_count <= group_count);

endmodule

bind issue_pair_counter issue_pair_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hazard(in_hazard),
  .group_count(group_count), .hazard_count(hazard_count)
);

// File: tb/issue_pair_counter_bench.sv
`timescale 1ns/1ps
module issue_pair_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_class = '0;
  logic        in_hazard = 1'b0;
  logic [31:0] group_count, hazard_count;
  logic [2:0]  sat_group, sat_hazard;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  issue_pair_counter u_issue_pair_counter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_hazard(in_hazard), .group_count(group_count), .hazard_count(hazard_count)
  );

  issue_pair_counter #(.CNT_W(3)) u_issue_pair_counter_sat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_hazard(in_hazard), .group_count(sat_group), .hazard_count(sat_hazard)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [3:0] cls, input logic haz);
    @(negedge clk);
    in_valid = 1'b1;
    in_class = cls;
    in_hazard = haz;
    @(negedge clk);
    in_valid = 1'b0;
    in_hazard = 1'b0;
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    chk("R1 groups in reset", group_count, 0);
    chk("R1 hazards in reset", hazard_count, 0);
    do_reset();
    send(4'd9, 1'b0);
    send(4'd9, 1'b0);
    do_reset();
    chk("R1 groups after reset", group_count, 0);
    send(4'd9, 1'b0);
    chk("R1 first after reset opens", group_count, 1);
  endtask

  task automatic t_slots_r3();
    do_reset();
    send(4'd9, 1'b0);
    chk("R2 first opens group", group_count, 1);
    send(4'd1, 1'b0);
    chk("R3 second shares group", group_count, 1);
    send(4'd9, 1'b0);
    chk("R3 third opens group", group_count, 2);
    chk("R3 no hazard counted", hazard_count, 0);
  endtask

  task automatic t_single_r4();
    do_reset();
    send(4'd3, 1'b0);
    send(4'd3, 1'b0);
    chk("R4 branch pair splits", group_count, 2);
    do_reset();
    send(4'd4, 1'b0);
    send(4'd4, 1'b0);
    chk("R4 jump pair splits", group_count, 2);
    do_reset();
    send(4'd2, 1'b0);
    send(4'd2, 1'b0);
    chk("R4 compare pair splits", group_count, 2);
  endtask

  task automatic t_double_r5();
    do_reset();
    send(4'd11, 1'b0);
    send(4'd10, 1'b0);
    chk("R5 load store share", group_count, 1);
    do_reset();
    send(4'd14, 1'b0);
    send(4'd0, 1'b0);
    chk("R5 code 14 as unknown shares", group_count, 1);
    send(4'd12, 1'b0);
    chk("R5 code 12 after full group", group_count, 2);
  endtask

  task automatic t_hazard_r6();
    do_reset();
    send(4'd9, 1'b1);
    chk("R6 hazard on first", hazard_count, 1);
    chk("R6 groups first", group_count, 1);
    send(4'd9, 1'b1);
    chk("R6 hazard breaks group", group_count, 2);
    chk("R6 hazard counted", hazard_count, 2);
    send(4'd9, 1'b0);
    chk("R6 slot left after hazard open", group_count, 2);
  endtask

  task automatic t_idle_r7();
    do_reset();
    send(4'd9, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    in_class = 4'd3;
    in_hazard = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 idle groups", group_count, 1);
    chk("R7 idle hazards", hazard_count, 0);
    send(4'd9, 1'b0);
    chk("R7 slot state kept", group_count, 1);
  endtask

  task automatic t_mixed_r9();
    do_reset();
    send(4'd2, 1'b0);
    send(4'd3, 1'b0);
    chk("R9 compare branch share", group_count, 1);
    send(4'd4, 1'b0);
    send(4'd2, 1'b0);
    chk("R9 jump compare share", group_count, 2);
  endtask

  task automatic t_sat_r8();
    do_reset();
    for (int i = 0; i < 10; i++) send(4'd3, 1'b1);
    chk("R8 wide groups", group_count, 10);
    chk("R8 narrow groups saturate", {29'd0, sat_group}, 7);
    chk("R8 narrow hazards saturate", {29'd0, sat_hazard}, 7);
  endtask

  initial begin
    t_reset_r1();
    t_slots_r3();
    t_single_r4();
    t_double_r5();
    t_hazard_r6();
    t_idle_r7();
    t_mixed_r9();
    t_sat_r8();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule